// File: doc/BRIEF.md
# Protection Key Check Unit

This block decides whether a memory access may proceed, given the protection key attached to its translation. It keeps a small file of key entries. Each entry holds a key value, a valid flag and three deny flags, one each for loads, stores and instruction fetch. Software fills and replaces the entries through a write port; the hardware never evicts or allocates an entry on its own.

For each request, the request key is compared against every valid entry in parallel. No match gives a key-miss fault. If entries match, the lowest-indexed one supplies its deny flags. A set deny flag for the requested access kind gives a key-permission fault. A global enable input turns checking off, and then every access is let through.

The verdict is registered. It appears one cycle after the request, qualified by a single response strobe, together with the index of the entry that matched.

Top module: `pkey_check`

## Requirements
- R1: After reset every entry is invalid and `rsp_valid` is low, so a checked request for any key, including key zero, reports a miss.
- R2: `rsp_valid` is high in the cycle after `req_valid` was high and low otherwise; back-to-back requests give back-to-back responses, one per request.
- R3: With checking enabled, a request whose key equals no valid entry's key gets `rsp_miss` = 1, `rsp_perm` = 0 and `rsp_hit_idx` = 0.
- R4: An entry written with its valid flag at 0 never matches, even when its stored key equals the request key.
- R5: Access kinds are encoded on `req_kind` as 0 = read, 1 = write and 2 = execute. When the winning entry's deny flag for that kind is set, the response is `rsp_perm` = 1 and `rsp_miss` = 0. Otherwise both are 0. In both cases `rsp_hit_idx` is the winning index.
- R6: `req_kind` = 3 is a probe. It reports a miss or a hit like any request, but never raises `rsp_perm`.
- R7: When several valid entries match, the lowest index wins: `rsp_hit_idx` names it, and only its deny flags are applied.
- R8: When `chk_en` is low in the request cycle, the response has `rsp_miss` = 0, `rsp_perm` = 0 and `rsp_hit_idx` = 0.
- R9: A write to the entry file is seen by requests issued in later cycles. A request issued in the same cycle as a write is judged against the contents from before that write.
- R10: `rsp_miss` and `rsp_perm` are never both high, and all three result outputs are zero whenever `rsp_valid` is low.
- R11: Rewriting an entry with its valid flag at 0 removes it, so its former key then misses; the highest index works like any other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chk_en | input | 1 | Global check enable, sampled with the request |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | 4 | Entry index to write |
| wr_key | input | 24 | Key value to store |
| wr_rd_deny | input | 1 | Deny reads for this key |
| wr_wr_deny | input | 1 | Deny writes for this key |
| wr_ex_deny | input | 1 | Deny execution for this key |
| wr_valid | input | 1 | Valid flag to store |
| req_valid | input | 1 | Access request strobe |
| req_key | input | 24 | Key of the access |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 probe |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_miss | output | 1 | Key-miss fault |
| rsp_perm | output | 1 | Key-permission fault |
| rsp_hit_idx | output | 4 | Index of the winning entry, 0 on miss or when disabled |

## Verification
A corrupted entry shows up at the ports only when a request touches its key. It then appears in the very next response as a wrong miss, a missing or extra permission fault, or a wrong `rsp_hit_idx`. A broken priority order shows up the same way, so the bench aims requests at duplicate keys, at invalidated entries and at the last index. Each response is compared against a model the bench keeps of every write. A same-cycle write and request pair shows whether a write leaks into the lookup one cycle too early.

// File: rtl/pkey_pkg.sv
package pkey_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_PROBE = 2'd3
    } acc_kind_e;

    // Per-entry flags: valid plus one deny bit per access kind
    typedef struct packed {
        logic vld;
        logic no_rd;
        logic no_wr;
        logic no_ex;
    } kflags_t;

endpackage

// File: rtl/pkey_entry_file.sv
module pkey_entry_file
    import pkey_pkg::*;
#(
    parameter int NUM_KEYS = 16,
    parameter int KEY_W    = 24,
    parameter int IDX_W    = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [IDX_W-1:0]               wr_idx,
    input  logic [KEY_W-1:0]               wr_key,
    input  kflags_t                        wr_flags,
    output logic [NUM_KEYS-1:0][KEY_W-1:0] keys_o,
    output kflags_t [NUM_KEYS-1:0]         flags_o
);

    typedef struct packed {
        logic [KEY_W-1:0] key;
        kflags_t          fl;
    } ent_t;

    for (genvar g = 0; g < NUM_KEYS; g++) begin : g_ent
        ent_t ent_d, ent_q;

        always_comb begin
            ent_d = ent_q;
            if (wr_en && (wr_idx == IDX_W'(g))) begin
                ent_d.key = wr_key;
                ent_d.fl  = wr_flags;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent_q <= '0;
            end else begin
                ent_q <= ent_d;
            end
        end

        assign keys_o[g]  = ent_q.key;
        assign flags_o[g] = ent_q.fl;
    end

endmodule

// File: rtl/pkey_match.sv
module pkey_match
    import pkey_pkg::*;
#(
    parameter int NUM_KEYS = 16,
    parameter int KEY_W    = 24,
    parameter int IDX_W    = 4
) (
    input  logic [NUM_KEYS-1:0][KEY_W-1:0] keys_i,
    input  kflags_t [NUM_KEYS-1:0]         flags_i,
    input  logic [KEY_W-1:0]               req_key,
    output logic                           hit_o,
    output logic [IDX_W-1:0]               hit_idx_o,
    output kflags_t                        hit_flags_o
);

    logic [NUM_KEYS-1:0] eq;

    for (genvar g = 0; g < NUM_KEYS; g++) begin : g_cmp
        assign eq[g] = flags_i[g].vld && (keys_i[g] == req_key);
    end

    // Walk downward so the lowest matching index is assigned last
    always_comb begin
        hit_o       = |eq;
        hit_idx_o   = '0;
        hit_flags_o = '0;
        for (int i = NUM_KEYS - 1; i >= 0; i--) begin
            if (eq[i]) begin
                hit_idx_o   = IDX_W'(i);
                hit_flags_o = flags_i[i];
            end
        end
    end

endmodule

// File: rtl/pkey_check.sv
module pkey_check
    import pkey_pkg::*;
#(
    parameter  int NUM_KEYS = 16,
    parameter  int KEY_W    = 24,
    localparam int IDX_W    = (NUM_KEYS > 1) ? $clog2(NUM_KEYS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chk_en,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [KEY_W-1:0] wr_key,
    input  logic             wr_rd_deny,
    input  logic             wr_wr_deny,
    input  logic             wr_ex_deny,
    input  logic             wr_valid,
    input  logic             req_valid,
    input  logic [KEY_W-1:0] req_key,
    input  logic [1:0]       req_kind,
    output logic             rsp_valid,
    output logic             rsp_miss,
    output logic             rsp_perm,
    output logic [IDX_W-1:0] rsp_hit_idx
);

    typedef struct packed {
        logic             vld;
        logic             miss;
        logic             perm;
        logic [IDX_W-1:0] idx;
    } rsp_t;

    kflags_t                        wr_flags;
    logic [NUM_KEYS-1:0][KEY_W-1:0] keys;
    kflags_t [NUM_KEYS-1:0]         flags;
    logic                           hit;
    logic [IDX_W-1:0]               hit_idx;
    kflags_t                        hit_flags;
    rsp_t                           rsp_d, rsp_q;

    assign wr_flags = '{vld: wr_valid, no_rd: wr_rd_deny,
                        no_wr: wr_wr_deny, no_ex: wr_ex_deny};

    pkey_entry_file #(
        .NUM_KEYS (NUM_KEYS),
        .KEY_W    (KEY_W),
        .IDX_W    (IDX_W)
    ) u_file (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_key   (wr_key),
        .wr_flags (wr_flags),
        .keys_o   (keys),
        .flags_o  (flags)
    );

    pkey_match #(
        .NUM_KEYS (NUM_KEYS),
        .KEY_W    (KEY_W),
        .IDX_W    (IDX_W)
    ) u_match (
        .keys_i      (keys),
        .flags_i     (flags),
        .req_key     (req_key),
        .hit_o       (hit),
        .hit_idx_o   (hit_idx),
        .hit_flags_o (hit_flags)
    );

    always_comb begin
        rsp_d = '0;
        if (req_valid) begin
            rsp_d.vld = 1'b1;
            if (chk_en) begin
                if (!hit) begin
                    rsp_d.miss = 1'b1;
                end else begin
                    rsp_d.idx = hit_idx;
                    case (acc_kind_e'(req_kind))
                        ACC_READ:  rsp_d.perm = hit_flags.no_rd;
                        ACC_WRITE: rsp_d.perm = hit_flags.no_wr;
                        ACC_EXEC:  rsp_d.perm = hit_flags.no_ex;
                        default:   rsp_d.perm = 1'b0;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid   = rsp_q.vld;
    assign rsp_miss    = rsp_q.miss;
    assign rsp_perm    = rsp_q.perm;
    assign rsp_hit_idx = rsp_q.idx;

endmodule

// File: rtl/pkey_check_chk.sv
module pkey_check_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       chk_en,
    input logic       req_valid,
    input logic [1:0] req_kind,
    input logic       rsp_valid,
    input logic       rsp_miss,
    input logic       rsp_perm
);

    // R2
    rsp_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R2
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R10
    faults_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_miss && rsp_perm));

    // R10
    quiet_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_miss && !rsp_perm));

    // R8
    disabled_passes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !chk_en) |=> (!rsp_miss && !rsp_perm));

    // R6
    probe_no_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 2'd3) |=> !rsp_perm);

endmodule

bind pkey_check pkey_check_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .chk_en    (chk_en),
    .req_valid (req_valid),
    .req_kind  (req_kind),
    .rsp_valid (rsp_valid),
    .rsp_miss  (rsp_miss),
    .rsp_perm  (rsp_perm)
);

// File: tb/pkey_check_bench.sv
`timescale 1ns/1ps
module pkey_check_bench;

    localparam int NK = 16;
    localparam int KW = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          chk_en = 1'b1;
    logic          wr_en = 1'b0;
    logic [3:0]    wr_idx = '0;
    logic [KW-1:0] wr_key = '0;
    logic          wr_rd_deny = 1'b0;
    logic          wr_wr_deny = 1'b0;
    logic          wr_ex_deny = 1'b0;
    logic          wr_valid = 1'b0;
    logic          req_valid = 1'b0;
    logic [KW-1:0] req_key = '0;
    logic [1:0]    req_kind = '0;
    logic          rsp_valid, rsp_miss, rsp_perm;
    logic [3:0]    rsp_hit_idx;

    always #10 clk = ~clk;

    pkey_check #(.NUM_KEYS(NK), .KEY_W(KW)) u_pkey_check (
        .clk (clk), .rst_n (rst_n), .chk_en (chk_en),
        .wr_en (wr_en), .wr_idx (wr_idx), .wr_key (wr_key),
        .wr_rd_deny (wr_rd_deny), .wr_wr_deny (wr_wr_deny),
        .wr_ex_deny (wr_ex_deny), .wr_valid (wr_valid),
        .req_valid (req_valid), .req_key (req_key), .req_kind (req_kind),
        .rsp_valid (rsp_valid), .rsp_miss (rsp_miss), .rsp_perm (rsp_perm),
        .rsp_hit_idx (rsp_hit_idx)
    );

    typedef struct {
        logic       miss;
        logic       perm;
        logic [3:0] idx;
        string      tag;
    } exp_t;

    exp_t q[$];
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Bench-side model of the entry file
    logic [KW-1:0] m_key [NK];
    logic          m_vld [NK];
    logic          m_rd  [NK];
    logic          m_wr  [NK];
    logic          m_ex  [NK];

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic exp_t predict(input logic [KW-1:0] k, input logic [1:0] kind,
                                     input logic en, input string tag);
        exp_t e;
        e.miss = 1'b0; e.perm = 1'b0; e.idx = '0; e.tag = tag;
        if (en) begin
            e.miss = 1'b1;
            for (int i = NK - 1; i >= 0; i--) begin
                if (m_vld[i] && m_key[i] == k) begin
                    e.miss = 1'b0;
                    e.idx  = 4'(i);
                    e.perm = (kind == 2'd0) ? m_rd[i] :
                             (kind == 2'd1) ? m_wr[i] :
                             (kind == 2'd2) ? m_ex[i] : 1'b0;
                end
            end
        end
        return e;
    endfunction

    // Drive a request at a falling edge and leave it asserted
    task automatic issue(input logic [KW-1:0] k, input logic [1:0] kind,
                         input logic en, input string tag);
        @(negedge clk);
        q.push_back(predict(k, kind, en, tag));
        req_valid = 1'b1; req_key = k; req_kind = kind; chk_en = en;
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0; wr_en = 1'b0; chk_en = 1'b1;
    endtask

    task automatic access(input logic [KW-1:0] k, input logic [1:0] kind,
                          input logic en, input string tag);
        issue(k, kind, en, tag);
        idle();
    endtask

    task automatic drive_write(input int idx, input logic [KW-1:0] k, input logic rd,
                               input logic wr, input logic ex, input logic v);
        wr_en = 1'b1; wr_idx = 4'(idx); wr_key = k;
        wr_rd_deny = rd; wr_wr_deny = wr; wr_ex_deny = ex; wr_valid = v;
    endtask

    task automatic mirror(input int idx, input logic [KW-1:0] k, input logic rd,
                          input logic wr, input logic ex, input logic v);
        m_key[idx] = k; m_rd[idx] = rd; m_wr[idx] = wr; m_ex[idx] = ex; m_vld[idx] = v;
    endtask

    task automatic write_entry(input int idx, input logic [KW-1:0] k, input logic rd,
                               input logic wr, input logic ex, input logic v);
        @(negedge clk);
        drive_write(idx, k, rd, wr, ex, v);
        mirror(idx, k, rd, wr, ex, v);
        idle();
    endtask

    // R9: write and request in the same cycle; expectation uses old contents
    task automatic write_with_req(input int idx, input logic [KW-1:0] k);
        @(negedge clk);
        q.push_back(predict(k, 2'd0, 1'b1, "R9 same-cycle"));
        req_valid = 1'b1; req_key = k; req_kind = 2'd0; chk_en = 1'b1;
        drive_write(idx, k, 1'b0, 1'b0, 1'b0, 1'b1);
        mirror(idx, k, 1'b0, 1'b0, 1'b0, 1'b1);
        idle();
    endtask

    // Scoreboard monitor
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rst_n && rsp_valid) begin
                if (q.size() == 0) begin
                    check("R2 unexpected response", 1, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check({e.tag, " miss"}, int'(rsp_miss), int'(e.miss));
                    check({e.tag, " perm"}, int'(rsp_perm), int'(e.perm));
                    check({e.tag, " idx"},  int'(rsp_hit_idx), int'(e.idx));
                end
            end else if (rst_n) begin
                check("R10 idle outputs", int'({rsp_miss, rsp_perm, rsp_hit_idx}), 0);
            end
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NK; i++) mirror(i, '0, 1'b0, 1'b0, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        check("R1 rsp_valid in reset", int'(rsp_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 rsp_valid after reset", int'(rsp_valid), 0);
        access(24'h000000, 2'd0, 1'b1, "R1 empty file");

        // R3 / R5: plain hit, every kind allowed
        write_entry(3, 24'hABCDEF, 0, 0, 0, 1);
        access(24'hABCDEF, 2'd0, 1'b1, "R3 hit read");
        access(24'hABCDEF, 2'd1, 1'b1, "R5 hit write");
        access(24'hABCDEF, 2'd2, 1'b1, "R5 hit exec");

        // R5: write denied
        write_entry(5, 24'h123456, 0, 1, 0, 1);
        access(24'h123456, 2'd1, 1'b1, "R5 write deny");
        access(24'h123456, 2'd0, 1'b1, "R5 read ok");
        access(24'h123456, 2'd2, 1'b1, "R5 exec ok");

        // R5 / R6: read and exec denied, probe never faults
        write_entry(7, 24'h0F0F0F, 1, 0, 1, 1);
        access(24'h0F0F0F, 2'd2, 1'b1, "R5 exec deny");
        access(24'h0F0F0F, 2'd0, 1'b1, "R5 read deny");
        access(24'h0F0F0F, 2'd1, 1'b1, "R5 write ok");
        access(24'h0F0F0F, 2'd3, 1'b1, "R6 probe hit");
        access(24'h777777, 2'd3, 1'b1, "R6 probe miss");

        // R3: unknown key
        access(24'h777777, 2'd0, 1'b1, "R3 miss");

        // R4: invalid entry with matching key
        write_entry(9, 24'h555555, 1, 1, 1, 0);
        access(24'h555555, 2'd1, 1'b1, "R4 invalid entry");

        // R7: duplicates, lowest index decides
        write_entry(12, 24'hABCDEF, 1, 1, 1, 1);
        access(24'hABCDEF, 2'd0, 1'b1, "R7 lower wins");
        write_entry(2, 24'hABCDEF, 1, 0, 0, 1);
        access(24'hABCDEF, 2'd0, 1'b1, "R7 new lowest deny");
        access(24'hABCDEF, 2'd1, 1'b1, "R7 new lowest allow");

        // R8: checking disabled
        access(24'h777777, 2'd0, 1'b0, "R8 disabled miss");
        access(24'h0F0F0F, 2'd2, 1'b0, "R8 disabled deny");

        // R9: same-cycle write unseen, then seen
        write_with_req(0, 24'h999999);
        access(24'h999999, 2'd0, 1'b1, "R9 after write");

        // R11: removal and top index
        write_entry(5, 24'h123456, 0, 0, 0, 0);
        access(24'h123456, 2'd0, 1'b1, "R11 removed");
        write_entry(15, 24'hFFFFFF, 0, 0, 1, 1);
        access(24'hFFFFFF, 2'd2, 1'b1, "R11 top index");

        // R2: back-to-back requests
        issue(24'hABCDEF, 2'd0, 1'b1, "R2 burst 0");
        issue(24'h777777, 2'd1, 1'b1, "R2 burst 1");
        issue(24'h0F0F0F, 2'd0, 1'b1, "R2 burst 2");
        issue(24'hFFFFFF, 2'd1, 1'b1, "R2 burst 3");
        idle();
        repeat (3) @(negedge clk);
        check("R2 all responses seen", q.size(), 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule